// File: doc/BRIEF.md
# Flash Page Buffer Load Sequencer

This block owns the 128-word staging buffer that sits between a flash command front end and the program engine of a two-bank NOR array. The front end hands it a buffer command code that it has already recognised, followed by the bus write cycles that belong to that command. The sequencer uses these cycles to fill the buffer, clear it, or start a program of the staged page.

There are two ways to fill the buffer. In the random mode, each command places one word at a column of the caller's choice. In the streaming mode, one command is followed by 128 data writes that must run upward from column 0 to column 127 without gaps. Either mode can end in a program request. The engine then reads the page word by word through a read port, where columns that were never written return the erased value FFFFh. When the engine reports completion, the sequencer empties the buffer.

Any cycle that breaks the expected sequence produces a one-cycle error pulse. This covers a wrong column, a page that moves during a stream, a confirm byte that is not D0h, and a bank-restricted operation aimed at the wrong bank.

Top module: `pgbuf_seq`

## Requirements
- R1: While reset is held and just after it, busy, prog_req and seq_err are low, and eng_word reads FFFFh for every column.
- R2: Command 74h followed by one write whose address has bits [19:17] = 000 (bank I) stores wr_data at column wr_addr[6:0]. Other columns are unaffected.
- R3: A single-load data write, or a buffer-program confirm, whose address lies outside bank I (bits [19:17] not 000) raises seq_err for one cycle, changes no column and starts no program.
- R4: Command 55h followed by a write with low data byte D0h makes every column read FFFFh, without an error.
- R5: A confirm write after 55h or 0Eh whose low data byte is not D0h raises seq_err, leaves the buffer contents unchanged, and returns the block to idle.
- R6: Command 41h followed by 128 writes with columns 0 to 127 in order and constant address bits [19:7] fills the buffer in either bank. After the last write, it raises a program request for that page.
- R7: During streaming, a write whose column is not the next expected one, or whose bits [19:7] differ from the first write, raises seq_err, empties the buffer and returns the block to idle.
- R8: A program request is a one-cycle prog_req pulse, issued after 0Eh plus a D0h confirm or after a complete stream. prog_page carries address bits [19:7] of the last write. busy stays high until prog_done.
- R9: While busy, command and write cycles have no effect on the buffer and raise no error.
- R10: prog_done while busy drops busy and makes every column read FFFFh.
- R11: eng_word returns the stored word for a loaded column and FFFFh for an unloaded one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | A recognised buffer command is on cmd_code |
| cmd_code | input | 8 | Command code: 74h, 41h, 0Eh or 55h |
| wr_vld | input | 1 | Data or confirm write cycle |
| wr_addr | input | 20 | Write address; [6:0] column, [19:7] page, [19:17] bank field |
| wr_data | input | 16 | Write data |
| prog_done | input | 1 | Program engine has finished |
| eng_col | input | 7 | Column read by the program engine |
| prog_req | output | 1 | One-cycle program request |
| prog_page | output | 13 | Page address for the request |
| busy | output | 1 | Waiting for the engine |
| seq_err | output | 1 | One-cycle sequence error pulse |
| eng_word | output | 16 | Buffered word at eng_col, or FFFFh |

## Verification
The assertions assume the following about the front end:
- cmd_vld and wr_vld are never high in the same cycle.
- prog_done arrives only while busy is high.

If these assumptions are broken, the pulse-width and hold properties would not describe the intended behaviour. The stimulus drives exactly one bus cycle per clock through tasks that pulse a single valid strobe. It raises prog_done only after busy has been observed high.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD1,
    ST_STREAM,
    ST_CPROG,
    ST_CCLR,
    ST_BUSY
  } seq_state_e;

  localparam logic [7:0] OP_LOAD1   = 8'h74;
  localparam logic [7:0] OP_STREAM  = 8'h41;
  localparam logic [7:0] OP_BUFPROG = 8'h0E;
  localparam logic [7:0] OP_CLEAR   = 8'h55;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 16,
  localparam int COL_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [COL_W-1:0]  wcol,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [COL_W-1:0]  rcol,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;

  // data array carries no reset; the valid map masks it
  always_ff @(posedge clk) begin
    if (we) mem_q[wcol] <= wdata;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  valid_q[i] <= 1'b0;
      else if (clr)                                valid_q[i] <= 1'b0;
      else if (we && (wcol == COL_W'(i)))          valid_q[i] <= 1'b1;
    end
  end

  assign rword = valid_q[rcol] ? mem_q[rcol] : {DATA_W{1'b1}};

  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_q == '0));
  p_write_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> valid_q[$past(wcol)]);
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
  import pgbuf_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 20,
  parameter int BANK_W   = 3,
  parameter logic [BANK_W-1:0] BANK1_TAG = '0,
  localparam int COL_W   = $clog2(DEPTH),
  localparam int PAGE_W  = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [7:0]        cmd_code,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              st_we,
  output logic [COL_W-1:0]  st_col,
  output logic [DATA_W-1:0] st_data,
  output logic              st_clr,
  output logic              prog_req,
  output logic [PAGE_W-1:0] prog_page,
  output logic              busy,
  output logic              seq_err
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(DEPTH - 1);

  seq_state_e        state_q, state_n;
  logic [COL_W-1:0]  cnt_q, cnt_n;
  logic              cnt_en;
  logic [PAGE_W-1:0] page_q, page_n;
  logic              page_en;
  logic              req_q, req_n;
  logic              err_q, err_n;

  logic [COL_W-1:0]  w_col;
  logic [PAGE_W-1:0] w_page;
  logic              w_bank1;
  logic              w_confirm;
  logic              stream_ok;

  assign w_col     = wr_addr[COL_W-1:0];
  assign w_page    = wr_addr[ADDR_W-1:COL_W];
  assign w_bank1   = (wr_addr[ADDR_W-1 -: BANK_W] == BANK1_TAG);
  assign w_confirm = (wr_data[7:0] == OP_CONFIRM);
  assign stream_ok = (w_col == cnt_q) && ((cnt_q == '0) || (w_page == page_q));

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    page_n  = w_page;
    page_en = 1'b0;
    req_n   = 1'b0;
    err_n   = 1'b0;
    st_we   = 1'b0;
    st_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_vld) begin
        unique case (cmd_code)
          OP_LOAD1:   state_n = ST_LOAD1;
          OP_STREAM:  begin state_n = ST_STREAM; cnt_n = '0; cnt_en = 1'b1; end
          OP_BUFPROG: state_n = ST_CPROG;
          OP_CLEAR:   state_n = ST_CCLR;
          default:    state_n = ST_IDLE;
        endcase
      end
      ST_LOAD1: if (wr_vld) begin
        state_n = ST_IDLE;
        if (w_bank1) st_we = 1'b1;
        else         err_n = 1'b1;
      end
      ST_STREAM: if (wr_vld) begin
        if (stream_ok) begin
          st_we   = 1'b1;
          page_en = 1'b1;
          if (cnt_q == LAST_COL) begin
            state_n = ST_BUSY;
            req_n   = 1'b1;
          end else begin
            cnt_n  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end else begin
          st_clr  = 1'b1;
          err_n   = 1'b1;
          state_n = ST_IDLE;
        end
      end
      ST_CPROG: if (wr_vld) begin
        if (w_confirm && w_bank1) begin
          state_n = ST_BUSY;
          req_n   = 1'b1;
          page_en = 1'b1;
        end else begin
          err_n   = 1'b1;
          state_n = ST_IDLE;
        end
      end
      ST_CCLR: if (wr_vld) begin
        state_n = ST_IDLE;
        if (w_confirm) st_clr = 1'b1;
        else           err_n  = 1'b1;
      end
      ST_BUSY: if (prog_done) begin
        st_clr  = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign st_col  = w_col;
  assign st_data = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      page_q  <= '0;
      req_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      req_q   <= req_n;
      err_q   <= err_n;
      if (cnt_en)  cnt_q  <= cnt_n;
      if (page_en) page_q <= page_n;
    end
  end

  assign prog_req  = req_q;
  assign prog_page = page_q;
  assign busy      = (state_q == ST_BUSY);
  assign seq_err   = err_q;

  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  p_req_with_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> busy);
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> (busy && $stable(prog_page)));
  p_done_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_done) |=> !busy);
  p_err_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (!prog_req && !busy));
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |-> (!st_we && !st_clr));
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq #(
  parameter int DEPTH   = 128,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 20,
  parameter int BANK_W  = 3,
  parameter logic [BANK_W-1:0] BANK1_TAG = '0,
  localparam int COL_W  = $clog2(DEPTH),
  localparam int PAGE_W = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [7:0]        cmd_code,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  input  logic [COL_W-1:0]  eng_col,
  output logic              prog_req,
  output logic [PAGE_W-1:0] prog_page,
  output logic              busy,
  output logic              seq_err,
  output logic [DATA_W-1:0] eng_word
);
  logic              st_we;
  logic [COL_W-1:0]  st_col;
  logic [DATA_W-1:0] st_data;
  logic              st_clr;

  pgbuf_ctrl #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .BANK_W(BANK_W), .BANK1_TAG(BANK1_TAG)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_done(prog_done),
    .st_we(st_we), .st_col(st_col), .st_data(st_data), .st_clr(st_clr),
    .prog_req(prog_req), .prog_page(prog_page),
    .busy(busy), .seq_err(seq_err)
  );

  pgbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(st_we), .wcol(st_col), .wdata(st_data), .clr(st_clr),
    .rcol(eng_col), .rword(eng_word)
  );
endmodule

// File: tb/pgbuf_seq_bench.sv
module pgbuf_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_vld;
  logic [7:0]  cmd_code;
  logic        wr_vld;
  logic [19:0] wr_addr;
  logic [15:0] wr_data;
  logic        prog_done;
  logic [6:0]  eng_col;
  logic        prog_req;
  logic [12:0] prog_page;
  logic        busy;
  logic        seq_err;
  logic [15:0] eng_word;

  int n_run = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  pgbuf_seq u_pgbuf_seq (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_done(prog_done), .eng_col(eng_col),
    .prog_req(prog_req), .prog_page(prog_page), .busy(busy),
    .seq_err(seq_err), .eng_word(eng_word)
  );

  // {kind[1:0] 1=cmd 2=write, code[7:0], addr[19:0], data[15:0], err, busy, req}
  localparam logic [48:0] VEC [12] = '{
    {2'd1, 8'h74, 20'h00000, 16'h0000, 3'b000},  // R2
    {2'd2, 8'h00, 20'h00005, 16'h1234, 3'b000},  // R2 col 5
    {2'd1, 8'h74, 20'h00000, 16'h0000, 3'b000},
    {2'd2, 8'h00, 20'h20003, 16'hAAAA, 3'b100},  // R3 bank II load
    {2'd1, 8'h74, 20'h00000, 16'h0000, 3'b000},
    {2'd2, 8'h00, 20'h0007F, 16'hBEEF, 3'b000},  // R2 col 127
    {2'd1, 8'h55, 20'h00000, 16'h0000, 3'b000},
    {2'd2, 8'h00, 20'h00000, 16'h00C5, 3'b100},  // R5 bad confirm
    {2'd1, 8'h0E, 20'h00000, 16'h0000, 3'b000},
    {2'd2, 8'h00, 20'h20000, 16'h00D0, 3'b100},  // R3 bank II confirm
    {2'd1, 8'h0E, 20'h00000, 16'h0000, 3'b000},
    {2'd2, 8'h00, 20'h00080, 16'h00D0, 3'b011}   // R8 program page 1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] code);
    cmd_vld = 1'b1; cmd_code = code;
    @(posedge clk); @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic do_wr(input logic [19:0] a, input logic [15:0] d);
    wr_vld = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_vld = 1'b0;
  endtask

  task automatic peek(input string req, input logic [6:0] c, input logic [15:0] exp);
    eng_col = c; #1;
    chk(req, 32'(eng_word), 32'(exp));
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_code = '0; wr_vld = 1'b0;
    wr_addr = '0; wr_data = '0; prog_done = 1'b0; eng_col = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req", 32'(prog_req), 0);
    chk("R1 err", 32'(seq_err), 0);
    peek("R1 word", 7'd0, 16'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    peek("R1 word after", 7'd127, 16'hFFFF);

    foreach (VEC[i]) begin
      if (VEC[i][48:47] == 2'd1) do_cmd(VEC[i][46:39]);
      else                       do_wr(VEC[i][38:19], VEC[i][18:3]);
      chk($sformatf("R3/R5/R8 err v%0d", i), 32'(seq_err), 32'(VEC[i][2]));
      chk($sformatf("R8 busy v%0d", i), 32'(busy), 32'(VEC[i][1]));
      chk($sformatf("R8 req v%0d", i), 32'(prog_req), 32'(VEC[i][0]));
    end
    chk("R8 page", 32'(prog_page), 32'h1);
    @(negedge clk);
    chk("R8 pulse ends", 32'(prog_req), 0);
    peek("R11 col5", 7'd5, 16'h1234);
    peek("R11 col127", 7'd127, 16'hBEEF);
    peek("R3 col3 untouched", 7'd3, 16'hFFFF);
    peek("R11 col6 unloaded", 7'd6, 16'hFFFF);

    // R9: cycles while busy are ignored
    do_cmd(8'h74);
    do_wr(20'h0000A, 16'h7777);
    chk("R9 err", 32'(seq_err), 0);
    chk("R9 busy", 32'(busy), 1);
    peek("R9 col10", 7'd10, 16'hFFFF);

    // R10: done clears
    prog_done = 1'b1; @(posedge clk); @(negedge clk); prog_done = 1'b0;
    chk("R10 busy", 32'(busy), 0);
    peek("R10 col5", 7'd5, 16'hFFFF);

    // R4: clear command
    do_cmd(8'h74); do_wr(20'h00009, 16'h5555);
    peek("R2 col9", 7'd9, 16'h5555);
    do_cmd(8'h55); do_wr(20'h00000, 16'h00D0);
    chk("R4 err", 32'(seq_err), 0);
    peek("R4 col9", 7'd9, 16'hFFFF);

    // R6: full stream in bank II
    do_cmd(8'h41);
    for (int c = 0; c < 128; c++) begin
      do_wr(20'h20100 | 20'(c), 16'h1000 + 16'(c));
      if (c == 126) chk("R6 no early req", 32'(prog_req), 0);
    end
    chk("R6 req", 32'(prog_req), 1);
    chk("R6 page", 32'(prog_page), 32'h402);
    peek("R6 col0", 7'd0, 16'h1000);
    peek("R6 col127", 7'd127, 16'h107F);
    prog_done = 1'b1; @(posedge clk); @(negedge clk); prog_done = 1'b0;
    chk("R10 after stream", 32'(busy), 0);

    // R7: skipped column
    do_cmd(8'h41);
    do_wr(20'h00200, 16'h0001);
    do_wr(20'h00201, 16'h0002);
    do_wr(20'h00203, 16'h0003);
    chk("R7 skip err", 32'(seq_err), 1);
    chk("R7 skip busy", 32'(busy), 0);
    peek("R7 skip discard", 7'd0, 16'hFFFF);

    // R7: page moves
    do_cmd(8'h41);
    do_wr(20'h00200, 16'h0011);
    do_wr(20'h00281, 16'h0022);
    chk("R7 page err", 32'(seq_err), 1);
    peek("R7 page discard", 7'd0, 16'hFFFF);

    summary();
    $finish;
  end
endmodule